// File: doc/BRIEF.md
# Twisted-Pair Link Integrity Controller

This block decides whether the receive side of a 10 Mb/s twisted-pair port has a working cable. It runs from a one-cycle millisecond strobe. It watches two inputs: single-cycle strobes that mark received link pulses, and a level that marks receive data activity. From these it keeps a pass/fail link state. While the link has failed, the transmit, receive and normal loopback paths are switched off. While the link passes, they are switched on.

A link pulse counts only when enough time has passed since the previous accepted pulse. A run of accepted pulses counts only while each pulse follows the one before it within a maximum spacing. The controller leaves the failed state when data activity is seen, or when the required number of well-spaced pulses has arrived. It enters the failed state when the link has been silent for the link-loss time.

Two inputs override the state machine. One disables link testing. The other forces a pass, as a board does by grounding the link indicator pin. Either input holds the link in pass.

Top module: `link_integrity_ctl`

## Requirements
- R1: After reset the link is failed: link_pass, xmit_en, rcvr_en and lpbk_en are all 0, and the accepted-pulse count is zero.
- R2: In pass, the link fails at the clock edge that samples the LOSS_MS-th millisecond strobe (default 60) since the last accepted pulse or data activity. It does not fail at the (LOSS_MS-1)-th strobe.
- R3: xmit_en, rcvr_en and lpbk_en are 1 exactly when link_pass is 1. They change in the same cycle as link_pass.
- R4: A link pulse is ignored if fewer than MIN_GAP_MS (default 4) strobes have passed since the last accepted pulse. An ignored pulse is not counted and does not restart the link-loss time.
- R5: A cycle with rx_active high moves a failed link to pass at the next edge. In pass, the same cycle restarts the link-loss time.
- R6: In fail, the link passes at the edge that samples the PULSES_NEEDED-th accepted pulse (default 2), provided each counted pulse followed the previous one by at most MAX_GAP_MS strobes. The first pulse after reset is accepted.
- R7: If more than MAX_GAP_MS (default 65) strobes pass with no accepted pulse, the count is cleared, and the next pulse counts as the first. A spacing of exactly MAX_GAP_MS still counts.
- R8: While test_en is 0, link_pass is 1 from the next edge onward, whatever the pulses, activity and elapsed time.
- R9: While force_pass is 1, link_pass is 1 from the next edge onward, whatever the pulses, activity and elapsed time.
- R10: In pass, each accepted link pulse restarts the link-loss time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe, once per millisecond |
| link_pulse | input | 1 | One-cycle strobe per received link pulse |
| rx_active | input | 1 | Received data activity on the pair |
| test_en | input | 1 | 1 enables link testing, 0 holds pass |
| force_pass | input | 1 | 1 forces link pass |
| link_pass | output | 1 | Link integrity status, 1 = pass |
| xmit_en | output | 1 | Transmit enable |
| rcvr_en | output | 1 | Receive enable |
| lpbk_en | output | 1 | Normal loopback enable |

## Verification
The assertions assume three things about the inputs. ms_tick and link_pulse are one-cycle strobes. A pulse and a tick never fall in the same cycle, so spacings in milliseconds have one meaning. rx_active is a cycle-level indication that needs no edge detection. The stimulus drives every strobe for exactly one cycle, puts ticks and pulses in separate cycles, and raises rx_active for single cycles only. All inputs change on the falling clock edge.

// File: rtl/lic_pkg.sv
package lic_pkg;

  typedef enum logic {
    LNK_FAIL = 1'b0,
    LNK_PASS = 1'b1
  } lnk_state_e;

  // true when a measured spacing reaches a lower bound
  function automatic logic reaches(input logic [31:0] v, input logic [31:0] lo);
    return v >= lo;
  endfunction

  // true when a measured spacing lies beyond an upper bound
  function automatic logic beyond(input logic [31:0] v, input logic [31:0] hi);
    return v > hi;
  endfunction

  // increment that stops at a limit
  function automatic logic [31:0] sat_inc(input logic [31:0] v, input logic [31:0] lim);
    return (v >= lim) ? lim : v + 32'd1;
  endfunction

endpackage

// File: rtl/lic_gap_timer.sv
module lic_gap_timer #(
  parameter int unsigned MAX_GAP_MS = 65,
  parameter int unsigned GW = $clog2(MAX_GAP_MS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ms_tick,
  input  logic          restart,
  output logic [GW-1:0] gap_ms,
  output logic          gap_expired
);
  import lic_pkg::*;

  localparam logic [GW-1:0] SAT_V = GW'(MAX_GAP_MS + 1);

  // milliseconds since the last accepted pulse; starts saturated
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_ms <= SAT_V;
    end else if (restart) begin
      gap_ms <= '0;
    end else if (ms_tick && (gap_ms != SAT_V)) begin
      gap_ms <= gap_ms + GW'(1);
    end
  end

  assign gap_expired = beyond(32'(gap_ms), MAX_GAP_MS);

endmodule

// File: rtl/lic_loss_timer.sv
module lic_loss_timer #(
  parameter int unsigned LOSS_MS = 60,
  parameter int unsigned LW = $clog2(LOSS_MS + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic run,
  input  logic refresh,
  output logic expire
);
  localparam logic [LW-1:0] LAST_V = LW'(LOSS_MS - 1);

  logic [LW-1:0] loss_ms;

  assign expire = run && !refresh && ms_tick && (loss_ms == LAST_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loss_ms <= '0;
    end else if (!run || refresh || expire) begin
      loss_ms <= '0;
    end else if (ms_tick) begin
      loss_ms <= loss_ms + LW'(1);
    end
  end

endmodule

// File: rtl/lic_pulse_qual.sv
module lic_pulse_qual #(
  parameter int unsigned MIN_GAP_MS    = 4,
  parameter int unsigned PULSES_NEEDED = 2,
  parameter int unsigned GW = 7,
  parameter int unsigned CW = $clog2(PULSES_NEEDED + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          link_pulse,
  input  logic          rx_active,
  input  logic          clear,
  input  logic [GW-1:0] gap_ms,
  input  logic          gap_expired,
  output logic          pulse_ok,
  output logic          enough,
  output logic [CW-1:0] pulse_cnt
);
  import lic_pkg::*;

  logic [CW-1:0] cnt_d;

  // a pulse is accepted only once the minimum spacing has elapsed
  assign pulse_ok = link_pulse && reaches(32'(gap_ms), MIN_GAP_MS);

  always_comb begin
    if (clear || rx_active) begin
      cnt_d = '0;
    end else if (pulse_ok) begin
      cnt_d = gap_expired ? CW'(1) : CW'(sat_inc(32'(pulse_cnt), PULSES_NEEDED));
    end else if (gap_expired) begin
      cnt_d = '0;
    end else begin
      cnt_d = pulse_cnt;
    end
  end

  assign enough = pulse_ok && !clear && !rx_active &&
                  reaches(32'(cnt_d), PULSES_NEEDED);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_cnt <= '0;
    else        pulse_cnt <= cnt_d;
  end

endmodule

// File: rtl/link_integrity_ctl.sv
module link_integrity_ctl #(
  parameter int unsigned LOSS_MS       = 60,
  parameter int unsigned MIN_GAP_MS    = 4,
  parameter int unsigned MAX_GAP_MS    = 65,
  parameter int unsigned PULSES_NEEDED = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ms_tick,
  input  logic link_pulse,
  input  logic rx_active,
  input  logic test_en,
  input  logic force_pass,
  output logic link_pass,
  output logic xmit_en,
  output logic rcvr_en,
  output logic lpbk_en
);
  import lic_pkg::*;

  localparam int unsigned GW = $clog2(MAX_GAP_MS + 2);
  localparam int unsigned CW = $clog2(PULSES_NEEDED + 1);

  lnk_state_e    state_q, state_d;
  logic          override;
  logic          pulse_ok, enough, gap_expired, loss_expire, loss_run;
  logic [GW-1:0] gap_ms;
  logic [CW-1:0] pulse_cnt;

  assign override = !test_en || force_pass;
  assign loss_run = (state_q == LNK_PASS) && !override;

  lic_gap_timer #(.MAX_GAP_MS(MAX_GAP_MS), .GW(GW)) u_gap (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .restart(pulse_ok),
    .gap_ms(gap_ms), .gap_expired(gap_expired)
  );

  lic_pulse_qual #(.MIN_GAP_MS(MIN_GAP_MS), .PULSES_NEEDED(PULSES_NEEDED),
                   .GW(GW), .CW(CW)) u_qual (
    .clk(clk), .rst_n(rst_n), .link_pulse(link_pulse), .rx_active(rx_active),
    .clear(state_q == LNK_PASS), .gap_ms(gap_ms), .gap_expired(gap_expired),
    .pulse_ok(pulse_ok), .enough(enough), .pulse_cnt(pulse_cnt)
  );

  lic_loss_timer #(.LOSS_MS(LOSS_MS)) u_loss (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .run(loss_run),
    .refresh(rx_active || pulse_ok), .expire(loss_expire)
  );

  always_comb begin
    state_d = state_q;
    if (override) begin
      state_d = LNK_PASS;
    end else begin
      case (state_q)
        LNK_PASS: if (loss_expire)          state_d = LNK_FAIL;
        LNK_FAIL: if (rx_active || enough)  state_d = LNK_PASS;
        default:                            state_d = LNK_FAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LNK_FAIL;
    else        state_q <= state_d;
  end

  // path enables kept in their own flops, loaded from the same next state
  logic [2:0] en_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= '0;
    else        en_q <= {3{state_d == LNK_PASS}};
  end

  assign link_pass = (state_q == LNK_PASS);
  assign xmit_en   = en_q[0];
  assign rcvr_en   = en_q[1];
  assign lpbk_en   = en_q[2];

endmodule

// File: rtl/link_integrity_ctl_chk.sv
module link_integrity_ctl_chk #(
  parameter int unsigned MIN_GAP_MS    = 4,
  parameter int unsigned PULSES_NEEDED = 2,
  parameter int unsigned GW = 7,
  parameter int unsigned CW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          ms_tick,
  input logic          link_pulse,
  input logic          rx_active,
  input logic          test_en,
  input logic          force_pass,
  input logic          link_pass,
  input logic          xmit_en,
  input logic          rcvr_en,
  input logic          lpbk_en,
  input logic [GW-1:0] gap_ms,
  input logic [CW-1:0] pulse_cnt
);
  localparam logic [GW-1:0] MIN_V  = GW'(MIN_GAP_MS);
  localparam logic [CW-1:0] NEED_V = CW'(PULSES_NEEDED);

  // R2: a passing link can only fail on a millisecond strobe
  assert_fail_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (link_pass && !ms_tick) |=> link_pass);

  // R3: all path enables follow the status flop
  assert_enables_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xmit_en == link_pass) && (rcvr_en == link_pass) && (lpbk_en == link_pass));

  // R4: an early pulse cannot bring a failed link back
  assert_early_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_pass && test_en && !force_pass && !rx_active && link_pulse && (gap_ms < MIN_V))
      |=> !link_pass);

  // R5: data activity always leaves the link passing
  assert_data_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_active |=> link_pass);

  // R6: a failed link needs a pulse or activity to recover
  assert_no_silent_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!link_pass && test_en && !force_pass && !rx_active && !link_pulse) |=> !link_pass);

  // R6: the pulse count never runs past its target
  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_cnt <= NEED_V);

  // R8, R9: overrides hold pass
  assert_override_R8_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!test_en || force_pass) |=> link_pass);

endmodule

bind link_integrity_ctl link_integrity_ctl_chk #(
  .MIN_GAP_MS(MIN_GAP_MS), .PULSES_NEEDED(PULSES_NEEDED), .GW(GW), .CW(CW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .link_pulse(link_pulse),
  .rx_active(rx_active), .test_en(test_en), .force_pass(force_pass),
  .link_pass(link_pass), .xmit_en(xmit_en), .rcvr_en(rcvr_en), .lpbk_en(lpbk_en),
  .gap_ms(gap_ms), .pulse_cnt(pulse_cnt)
);

// File: tb/link_integrity_ctl_test.sv
`timescale 1ns/1ps
module link_integrity_ctl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ms_tick = 1'b0, link_pulse = 1'b0, rx_active = 1'b0;
  logic test_en = 1'b1, force_pass = 1'b0;
  logic link_pass, xmit_en, rcvr_en, lpbk_en;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  link_integrity_ctl uut (
    .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .link_pulse(link_pulse),
    .rx_active(rx_active), .test_en(test_en), .force_pass(force_pass),
    .link_pass(link_pass), .xmit_en(xmit_en), .rcvr_en(rcvr_en), .lpbk_en(lpbk_en)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  // link status and all three enables together
  task automatic chk_all(input string req, input logic exp);
    chk({req, " link_pass"}, link_pass, exp);
    chk({req, " xmit_en R3"}, xmit_en, exp);
    chk({req, " rcvr_en R3"}, rcvr_en, exp);
    chk({req, " lpbk_en R3"}, lpbk_en, exp);
  endtask

  task automatic do_tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) ms_tick = 1'b1;
      @(negedge clk) ms_tick = 1'b0;
    end
  endtask

  task automatic send_pulse();
    @(negedge clk) link_pulse = 1'b1;
    @(negedge clk) link_pulse = 1'b0;
  endtask

  task automatic send_data();
    @(negedge clk) rx_active = 1'b1;
    @(negedge clk) rx_active = 1'b0;
  endtask

  task automatic t_reset();
    chk_all("R1 reset", 1'b0);
  endtask

  task automatic t_pulse_recover();
    send_pulse();
    chk_all("R6 one pulse", 1'b0);
    do_tick(10);
    send_pulse();
    chk_all("R6 second pulse", 1'b1);
  endtask

  task automatic t_loss();
    do_tick(59);
    chk_all("R2 before loss", 1'b1);
    do_tick(1);
    chk_all("R2 loss", 1'b0);
  endtask

  task automatic t_data();
    send_data();
    chk_all("R5 data recover", 1'b1);
    do_tick(50);
    send_data();
    do_tick(50);
    chk_all("R5 data refresh", 1'b1);
    for (int i = 0; i < 4; i++) begin
      do_tick(30);
      send_pulse();
    end
    do_tick(59);
    chk_all("R10 pulse refresh", 1'b1);
    do_tick(1);
    chk_all("R10 loss after last pulse", 1'b0);
  endtask

  task automatic t_early_fail();
    do_tick(10);
    send_pulse();
    chk_all("R4 first pulse", 1'b0);
    do_tick(2);
    send_pulse();
    chk_all("R4 early pulse ignored", 1'b0);
    do_tick(2);
    send_pulse();
    chk_all("R4 min spacing accepted", 1'b1);
  endtask

  task automatic t_early_pass();
    do_tick(5);
    send_pulse();
    do_tick(2);
    send_pulse();
    do_tick(57);
    chk_all("R4 pass before loss", 1'b1);
    do_tick(1);
    chk_all("R4 early pulse no refresh", 1'b0);
  endtask

  task automatic t_max_gap();
    do_tick(6);
    send_pulse();
    do_tick(66);
    send_pulse();
    chk_all("R7 gap too long", 1'b0);
    do_tick(65);
    send_pulse();
    chk_all("R7 gap at maximum", 1'b1);
  endtask

  task automatic t_test_off();
    do_tick(60);
    chk_all("R8 setup fail", 1'b0);
    @(negedge clk) test_en = 1'b0;
    @(negedge clk);
    chk_all("R8 disable forces pass", 1'b1);
    do_tick(200);
    chk_all("R8 held pass", 1'b1);
    test_en = 1'b1;
    do_tick(59);
    chk_all("R8 re-enabled", 1'b1);
    do_tick(1);
    chk_all("R8 loss after re-enable", 1'b0);
  endtask

  task automatic t_force();
    @(negedge clk) force_pass = 1'b1;
    @(negedge clk);
    chk_all("R9 force pass", 1'b1);
    send_pulse();
    send_pulse();
    do_tick(150);
    chk_all("R9 held pass", 1'b1);
    force_pass = 1'b0;
    do_tick(59);
    chk_all("R9 released", 1'b1);
    do_tick(1);
    chk_all("R9 loss after release", 1'b0);
  endtask

  initial begin
    #1;
    chk("R1 reset held link_pass", link_pass, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pulse_recover();
    t_loss();
    t_data();
    t_early_fail();
    t_early_pass();
    t_max_gap();
    t_test_off();
    t_force();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule